// File: doc/BRIEF.md
# Receive Queue Head Pointer Bank

This block holds one head descriptor pointer for each receive queue of a packet receiver, sixteen by default. Software loads a nonzero, word-aligned descriptor address into a queue's register over a small memory-mapped bus. That write arms the queue. The receive engine reads the armed flag and the pointer value of every queue straight from dedicated outputs. When the engine has used up all free buffers of a queue, it asks the bank to zero that queue's pointer, and the queue becomes idle again.

Some writes are illegal: a write to a queue that is still armed, or a write whose data has a nonzero low two bits. Such a write is dropped and the stored pointer does not change. The bank records the cause in one of two sticky per-queue error words. Software clears these words by writing ones to them. While any error bit is set, the bank holds a level interrupt high.

Top module: `rxq_head_bank`

## Requirements
- R1: After reset, every pointer reads 0x00000000, every armed flag is low, both error words are zero and `irq` is low.
- R2: A write to byte offset 0x600 + 4·n of an unarmed queue n, with write data bits [1:0] equal to 00, stores the data. If the data is nonzero, `q_armed[n]` is high in the cycle after the write and `q_ptr[32n+31:32n]` shows the data. Queue 15 sits at 0x63C and accepts 0xFFFFFFFC.
- R3: A read request (`rd_en` with an address) gives `rd_valid` high for exactly the next cycle, with `rd_data` holding the register value from the cycle of the request. `rd_valid` stays low when no read is requested.
- R4: A write to an armed queue is dropped, its pointer stays unchanged, and bit n of the busy-error word at offset 0x640 becomes 1.
- R5: A write with nonzero data bits [1:0] to an unarmed queue is dropped, the queue stays unarmed, and bit n of the alignment-error word at offset 0x644 becomes 1.
- R6: A write to an armed queue is classed as a busy error even if its data is misaligned. Only the busy bit is set and the alignment word does not change.
- R7: `clr_valid` high with queue index `clr_idx` zeroes that queue's pointer, and its armed flag is low in the next cycle.
- R8: When a hardware clear and a software write target the same queue in the same cycle, the clear wins. The write is dropped without setting any error bit. A retry of the same write in a later cycle is accepted.
- R9: Writing to 0x640 or 0x644 clears each error bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0.
- R10: `irq` is high exactly while at least one bit of either error word is set.
- R11: Reads of unmapped offsets (for example 0x5FC or 0x648) return zero. Writes to them change no pointer, flag or error bit.
- R12: Writing zero to an unarmed queue is legal. The queue stays unarmed and no error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data strobe, one cycle after `rd_en` |
| clr_valid | input | 1 | Receive engine request to zero a queue pointer |
| clr_idx | input | 4 | Queue index for `clr_valid` |
| q_armed | output | 16 | Per-queue armed flag |
| q_ptr | output | 512 | Per-queue pointer, queue n in bits [32n+31:32n] |
| irq | output | 1 | Level interrupt, high while any error bit is set |

## Verification
The hardest case to reach from the ports is a hardware clear and a software write arriving at the same queue on the same clock edge. It decides the R8 priority and whether a busy error is wrongly flagged. The bench first arms the queue with an ordinary write. On a single clock edge it then drives `clr_valid` with that queue's index together with a bus write to the same offset. It then checks that the pointer is zero and both error words are clean, and that a retry of the same write arms the queue. Busy-plus-misaligned writes are reached the same way, by arming the queue first and then writing data with low bits set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Which register space an access offset falls into
    typedef enum logic [1:0] {
        HIT_NONE      = 2'd0,
        HIT_QUEUE     = 2'd1,
        HIT_BUSY_ERR  = 2'd2,
        HIT_ALIGN_ERR = 2'd3
    } hit_e;
endpackage

// File: rtl/rxq_addr_decode.sv
module rxq_addr_decode
    import rxq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NUM_Q  = 16,
    parameter int unsigned QBASE  = 32'h600,
    localparam int unsigned IDX_W = $clog2(NUM_Q)
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_e              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(QBASE);
    localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(4 * NUM_Q);
    localparam logic [ADDR_W-1:0] BUSY_A  = ADDR_W'(QBASE + 4 * NUM_Q);
    localparam logic [ADDR_W-1:0] ALIGN_A = ADDR_W'(QBASE + 4 * NUM_Q + 4);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - BASE_A;
        hit = HIT_NONE;
        idx = rel[2 +: IDX_W];
        if (addr[1:0] == 2'b00 && addr >= BASE_A && rel < SPAN_A) begin
            hit = HIT_QUEUE;
        end else if (addr == BUSY_A) begin
            hit = HIT_BUSY_ERR;
        end else if (addr == ALIGN_A) begin
            hit = HIT_ALIGN_ERR;
        end
    end
endmodule

// File: rtl/rxq_slot.sv
module rxq_slot #(
    parameter int unsigned PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [PTR_W-1:0] sw_data,
    input  logic             hw_clr,
    output logic [PTR_W-1:0] ptr,
    output logic             armed,
    output logic             busy_set,
    output logic             align_set
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             armed;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d    = slot_q;
        busy_set  = 1'b0;
        align_set = 1'b0;
        if (hw_clr) begin
            // engine clear wins; a colliding write is dropped silently
            slot_d.ptr   = '0;
            slot_d.armed = 1'b0;
        end else if (sw_wr) begin
            if (slot_q.armed) begin
                busy_set = 1'b1;
            end else if (sw_data[1:0] != 2'b00) begin
                align_set = 1'b1;
            end else begin
                slot_d.ptr   = sw_data;
                slot_d.armed = |sw_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ptr   = slot_q.ptr;
    assign armed = slot_q.armed;
endmodule

// File: rtl/rxq_err_status.sv
module rxq_err_status #(
    parameter int unsigned NUM_Q = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] busy_set,
    input  logic [NUM_Q-1:0] align_set,
    input  logic             busy_w1c,
    input  logic             align_w1c,
    input  logic [NUM_Q-1:0] w1c_mask,
    output logic [NUM_Q-1:0] busy_err,
    output logic [NUM_Q-1:0] align_err,
    output logic             irq
);
    typedef struct packed {
        logic [NUM_Q-1:0] busy;
        logic [NUM_Q-1:0] align;
        logic             irq;
    } err_t;

    err_t err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (busy_w1c) begin
            err_d.busy = err_d.busy & ~w1c_mask;
        end
        if (align_w1c) begin
            err_d.align = err_d.align & ~w1c_mask;
        end
        err_d.busy  = err_d.busy | busy_set;
        err_d.align = err_d.align | align_set;
        err_d.irq   = (|err_d.busy) | (|err_d.align);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign busy_err  = err_q.busy;
    assign align_err = err_q.align;
    assign irq       = err_q.irq;
endmodule

// File: rtl/rxq_head_bank.sv
module rxq_head_bank
    import rxq_pkg::*;
#(
    parameter int unsigned NUM_Q  = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned QBASE  = 32'h600,
    localparam int unsigned IDX_W = $clog2(NUM_Q)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [PTR_W-1:0]       wr_data,
    output logic [PTR_W-1:0]       rd_data,
    output logic                   rd_valid,
    input  logic                   clr_valid,
    input  logic [IDX_W-1:0]       clr_idx,
    output logic [NUM_Q-1:0]       q_armed,
    output logic [NUM_Q*PTR_W-1:0] q_ptr,
    output logic                   irq
);
    hit_e                        hit;
    logic [IDX_W-1:0]            hit_idx;
    logic [NUM_Q-1:0][PTR_W-1:0] ptr_arr;
    logic [NUM_Q-1:0]            busy_set;
    logic [NUM_Q-1:0]            align_set;
    logic [NUM_Q-1:0]            busy_err_w;
    logic [NUM_Q-1:0]            align_err_w;

    rxq_addr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_Q  (NUM_Q),
        .QBASE  (QBASE)
    ) dec_i (
        .addr (addr),
        .hit  (hit),
        .idx  (hit_idx)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
        logic sw_wr_g;
        logic hw_clr_g;
        assign sw_wr_g  = wr_en && (hit == HIT_QUEUE) && (hit_idx == IDX_W'(g));
        assign hw_clr_g = clr_valid && (clr_idx == IDX_W'(g));

        rxq_slot #(.PTR_W(PTR_W)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sw_wr     (sw_wr_g),
            .sw_data   (wr_data),
            .hw_clr    (hw_clr_g),
            .ptr       (ptr_arr[g]),
            .armed     (q_armed[g]),
            .busy_set  (busy_set[g]),
            .align_set (align_set[g])
        );
    end

    rxq_err_status #(.NUM_Q(NUM_Q)) err_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_set  (busy_set),
        .align_set (align_set),
        .busy_w1c  (wr_en && hit == HIT_BUSY_ERR),
        .align_w1c (wr_en && hit == HIT_ALIGN_ERR),
        .w1c_mask  (wr_data[NUM_Q-1:0]),
        .busy_err  (busy_err_w),
        .align_err (align_err_w),
        .irq       (irq)
    );

    assign q_ptr = ptr_arr;

    // registered read port, one cycle latency
    typedef struct packed {
        logic             valid;
        logic [PTR_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        if (rd_en) begin
            unique case (hit)
                HIT_QUEUE:     rd_d.data = ptr_arr[hit_idx];
                HIT_BUSY_ERR:  rd_d.data = PTR_W'(busy_err_w);
                HIT_ALIGN_ERR: rd_d.data = PTR_W'(align_err_w);
                default:       rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;
endmodule

// File: rtl/rxq_head_bank_chk.sv
module rxq_head_bank_chk #(
    parameter int unsigned NUM_Q  = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned QBASE  = 32'h600,
    localparam int unsigned IDX_W = $clog2(NUM_Q)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [PTR_W-1:0]       wr_data,
    input logic                   rd_valid,
    input logic                   clr_valid,
    input logic [IDX_W-1:0]       clr_idx,
    input logic [NUM_Q-1:0]       q_armed,
    input logic [NUM_Q*PTR_W-1:0] q_ptr,
    input logic [NUM_Q-1:0]       busy_err,
    input logic [NUM_Q-1:0]       align_err,
    input logic                   irq
);
    assert_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_rd_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((|busy_err) || (|align_err)));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        localparam logic [ADDR_W-1:0] QA = ADDR_W'(QBASE + 4 * g);
        logic wr_here;
        logic clr_here;
        assign wr_here  = wr_en && (addr == QA);
        assign clr_here = clr_valid && (clr_idx == IDX_W'(g));

        assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_here && !clr_here && !q_armed[g] && wr_data[1:0] == 2'b00 && wr_data != '0)
            |=> (q_armed[g] && q_ptr[g*PTR_W +: PTR_W] == $past(wr_data)));

        assert_armed_tracks_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            q_armed[g] == (q_ptr[g*PTR_W +: PTR_W] != '0));

        assert_busy_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_here && !clr_here && q_armed[g])
            |=> ($stable(q_ptr[g*PTR_W +: PTR_W]) && busy_err[g]));

        assert_align_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_here && !clr_here && !q_armed[g] && wr_data[1:0] != 2'b00)
            |=> (!q_armed[g] && align_err[g]));

        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_here |=> (!q_armed[g] && q_ptr[g*PTR_W +: PTR_W] == '0));

        assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_here && wr_here && !busy_err[g])
            |=> !busy_err[g]);
    end
endmodule

bind rxq_head_bank rxq_head_bank_chk #(
    .NUM_Q  (NUM_Q),
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W),
    .QBASE  (QBASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .clr_valid (clr_valid),
    .clr_idx   (clr_idx),
    .q_armed   (q_armed),
    .q_ptr     (q_ptr),
    .busy_err  (busy_err_w),
    .align_err (align_err_w),
    .irq       (irq)
);

// File: tb/rxq_head_bank_tb_top.sv
module rxq_head_bank_tb_top;
    localparam int NQ = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          clr_valid = 1'b0;
    logic [3:0]    clr_idx = '0;
    logic [NQ-1:0] q_armed;
    logic [NQ*32-1:0] q_ptr;
    logic          irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    rxq_head_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .q_armed   (q_armed),
        .q_ptr     (q_ptr),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] qaddr(input int n);
        return 12'(12'h600 + 4 * n);
    endfunction

    function automatic logic [31:0] ptr_of(input int n);
        return q_ptr[n*32 +: 32];
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check("R3 rd_valid after request", 64'(rd_valid), 64'd1);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 armed after reset", 64'(q_armed), 64'd0);
        check("R1 pointers after reset", 64'(|q_ptr), 64'd0);
        check("R1 irq after reset", 64'(irq), 64'd0);
        check("R3 rd_valid idle", 64'(rd_valid), 64'd0);
        bus_read(12'h640, r);
        check("R1 busy word after reset", 64'(r), 64'd0);
        bus_read(12'h644, r);
        check("R1 align word after reset", 64'(r), 64'd0);
        @(negedge clk);
        check("R3 rd_valid drops", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_arm();
        logic [31:0] r;
        bus_write(qaddr(3), 32'h1000_0040);
        check("R2 q3 armed", 64'(q_armed[3]), 64'd1);
        check("R2 q3 pointer", 64'(ptr_of(3)), 64'h1000_0040);
        bus_read(qaddr(3), r);
        check("R3 read q3", 64'(r), 64'h1000_0040);
        bus_write(qaddr(15), 32'hFFFF_FFFC);
        check("R2 q15 armed at 0x63C", 64'(q_armed[15]), 64'd1);
        bus_read(12'h63C, r);
        check("R2 q15 value", 64'(r), 64'hFFFF_FFFC);
        bus_write(qaddr(0), 32'h0);
        check("R12 zero write leaves q0 idle", 64'(q_armed[0]), 64'd0);
        check("R12 zero write no error", 64'(irq), 64'd0);
    endtask

    task automatic t_busy();
        logic [31:0] r;
        bus_write(qaddr(3), 32'h2000_0000);
        check("R4 q3 pointer kept", 64'(ptr_of(3)), 64'h1000_0040);
        bus_read(12'h640, r);
        check("R4 busy bit 3", 64'(r), 64'h8);
        check("R10 irq on busy error", 64'(irq), 64'd1);
        bus_write(12'h640, 32'h0);
        bus_read(12'h640, r);
        check("R9 zero mask keeps bit", 64'(r), 64'h8);
        bus_write(12'h640, 32'h8);
        bus_read(12'h640, r);
        check("R9 w1c clears bit", 64'(r), 64'h0);
        check("R10 irq drops", 64'(irq), 64'd0);
    endtask

    task automatic t_align();
        logic [31:0] r;
        bus_write(qaddr(5), 32'h0000_0102);
        check("R5 q5 stays idle", 64'(q_armed[5]), 64'd0);
        check("R5 q5 pointer zero", 64'(ptr_of(5)), 64'd0);
        bus_read(12'h644, r);
        check("R5 align bit 5", 64'(r), 64'h20);
        check("R10 irq on align error", 64'(irq), 64'd1);
        bus_write(12'h644, 32'hFFFF_FFFF);
        bus_read(12'h644, r);
        check("R9 align w1c", 64'(r), 64'h0);
    endtask

    task automatic t_busy_over_align();
        logic [31:0] r;
        bus_write(qaddr(3), 32'h0000_0003);
        check("R6 pointer kept", 64'(ptr_of(3)), 64'h1000_0040);
        bus_read(12'h640, r);
        check("R6 busy bit set", 64'(r), 64'h8);
        bus_read(12'h644, r);
        check("R6 align word untouched", 64'(r), 64'h0);
        bus_write(12'h640, 32'h8);
    endtask

    task automatic t_hw_clear();
        @(negedge clk);
        clr_valid = 1'b1; clr_idx = 4'd3;
        @(negedge clk);
        clr_valid = 1'b0;
        check("R7 q3 disarmed", 64'(q_armed[3]), 64'd0);
        check("R7 q3 pointer zero", 64'(ptr_of(3)), 64'd0);
        check("R7 q15 untouched", 64'(ptr_of(15)), 64'hFFFF_FFFC);
        bus_write(qaddr(3), 32'h3000_0000);
        check("R7 q3 rearmed", 64'(ptr_of(3)), 64'h3000_0000);
    endtask

    task automatic t_collide();
        logic [31:0] r;
        bus_write(qaddr(7), 32'h0000_1000);
        @(negedge clk);
        clr_valid = 1'b1; clr_idx = 4'd7;
        wr_en = 1'b1; addr = qaddr(7); wr_data = 32'h0000_2000;
        @(negedge clk);
        clr_valid = 1'b0; wr_en = 1'b0;
        check("R8 clear wins pointer", 64'(ptr_of(7)), 64'd0);
        check("R8 no error on collision", 64'(irq), 64'd0);
        bus_read(12'h640, r);
        check("R8 busy word clean", 64'(r), 64'd0);
        bus_write(qaddr(7), 32'h0000_2000);
        check("R8 retry accepted", 64'(ptr_of(7)), 64'h0000_2000);
        check("R8 retry arms", 64'(q_armed[7]), 64'd1);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        logic [NQ*32-1:0] snap;
        snap = q_ptr;
        bus_write(12'h648, 32'hDEAD_BEEC);
        bus_write(12'h5FC, 32'h1234_5678);
        bus_write(12'h602, 32'h0000_4000);
        check("R11 pointers unchanged", 64'(q_ptr == snap), 64'd1);
        check("R11 no error raised", 64'(irq), 64'd0);
        bus_read(12'h648, r);
        check("R11 read 0x648", 64'(r), 64'd0);
        bus_read(12'h5FC, r);
        check("R11 read 0x5FC", 64'(r), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_busy();
        t_align();
        t_busy_over_align();
        t_hw_clear();
        t_collide();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule